// File: doc/BRIEF.md
# Host Bus Cycle Router

This block sits behind a 16-bit host bus. Each falling edge of an active-low chip enable begins one bus cycle. Two further active-low inputs classify the cycle. The command-enable input marks a command or a data cycle, and the write-enable input marks a write or a read. The router then names exactly one internal resource for the cycle. For a write, it pulses that resource's write strobe and presents the captured bus word. For a read, it pulses the read strobe and drives the resource's data back out through a read multiplexer while chip enable stays low.

Data cycles go to a sticky selection. A data read uses the current source, and a data write uses the current destination. Instructions written on the bus move the source or the destination among the comparand register, the two mask registers and the memory array. Command cycles normally go to the instruction decoder (writes) or the status register (reads). A one-shot override instruction redirects only the next command cycle, either to one of four configuration registers or to a readback of the current source or destination selection. After that cycle the override lapses.

The bus inputs are sampled on a free-running clock. A chip-enable falling edge is recognised when chip enable is sampled low after being sampled high.

Top module: `cycle_router`

## Requirements
- R1: A cycle starts at the clock edge where chip enable is first sampled low after being high. Command-enable low marks a command cycle and write-enable low marks a write. The selected resource's strobe is high for exactly one clock, in the clock that follows that edge. No second strobe occurs while chip enable stays low. Resource indices are: 0 comparand, 1 mask 1, 2 mask 2, 3 memory, 4 instruction decoder, 5 status, 6 control, 7 segment control, 8 address, 9 next-free address.
- R2: After reset, data reads and data writes both target the comparand, no strobe is active and the read output is not enabled.
- R3: With no override pending, a command write strobes the instruction decoder and a command read selects the status register. The instruction decoder is never read and the status register is never written.
- R4: Opcode 0x10+k (k = 0..3) sets the data source, and opcode 0x14+k sets the data destination. The code k is 0 comparand, 1 mask 1, 2 mask 2, 3 memory. The two selections are independent and hold until replaced.
- R5: Opcodes 0x20, 0x21, 0x22 and 0x23 make only the next command cycle, read or write, go to control, segment control, address or next-free address respectively. The cycle after that uses the defaults again.
- R6: Opcode 0x24 (source) or 0x25 (destination) makes the next command read return the 2-bit selection code in bits 1:0 with zeros above, with no strobe. A command write in that slot has no strobe and changes nothing.
- R7: A data cycle that arrives while an override is pending uses the normal data selection and cancels the override.
- R8: The opcode is bits 7:0 of a command write, and bits 15:8 are ignored. Any other opcode changes no selection.
- R9: The read enable is high only while chip enable is low after a read cycle has been captured. The read data is zero whenever the read enable is low.
- R10: During a write strobe, the write-data output carries the bus word captured at the cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low; falling edge starts a cycle |
| we_n | input | 1 | Write enable, active low (low = write) |
| cmd_n | input | 1 | Command enable, active low (low = command cycle) |
| bus_in | input | 16 | Host write data / opcode |
| res_rdata | input | 10x16 | Read data of each resource, indexed as in R1 |
| wr_stb | output | 10 | One-hot write strobe per resource |
| rd_stb | output | 10 | One-hot read strobe per resource |
| wr_data | output | 16 | Captured write word |
| rd_data | output | 16 | Read multiplexer output |
| rd_oe | output | 1 | Read output enable |

## Verification
A corrupted source, destination or override register does not show up on its own cycle. It shows at the next cycle that uses that register: the wrong strobe bit fires, or the wrong resource word appears on the read output. The stimulus therefore always follows an instruction with the cycle that consumes its effect. A stale override shows on the second command cycle after the instruction, as a strobe to a configuration register where the instruction decoder or status register was expected. A read enable held too long shows in the first clock after chip enable rises.

// File: rtl/cycle_router_pkg.sv
package cycle_router_pkg;

    localparam int DW    = 16;
    localparam int OPW   = 8;
    localparam int NRES  = 10;
    localparam int RIW   = $clog2(NRES);

    localparam int RES_CMP   = 0;
    localparam int RES_MSK1  = 1;
    localparam int RES_MSK2  = 2;
    localparam int RES_MEM   = 3;
    localparam int RES_INSTR = 4;
    localparam int RES_STAT  = 5;
    localparam int RES_CTRL  = 6;
    localparam int RES_SEG   = 7;
    localparam int RES_ADDR  = 8;
    localparam int RES_NFREE = 9;

    typedef enum logic [1:0] {DSEL_CMP, DSEL_MSK1, DSEL_MSK2, DSEL_MEM} dsel_e;
    typedef enum logic [2:0] {OVR_CTRL, OVR_SEG, OVR_ADDR, OVR_NFREE,
                              OVR_PSRC, OVR_PDST} ovr_e;
    typedef enum logic [1:0] {OP_NONE, OP_SRC, OP_DST, OP_OVR} opk_e;

    typedef struct packed {
        opk_e       kind;
        logic [2:0] arg;
    } opdec_t;

    function automatic opdec_t decode_op(input logic [OPW-1:0] op);
        opdec_t d;
        d.kind = OP_NONE;
        d.arg  = 3'd0;
        if (op[7:2] == 6'b000100) begin
            d.kind = OP_SRC; d.arg = {1'b0, op[1:0]};
        end else if (op[7:2] == 6'b000101) begin
            d.kind = OP_DST; d.arg = {1'b0, op[1:0]};
        end else if (op[7:3] == 5'b00100 && op[2:0] <= 3'd5) begin
            d.kind = OP_OVR; d.arg = op[2:0];
        end
        return d;
    endfunction

    function automatic logic [RIW-1:0] dsel_res(input dsel_e s);
        return RIW'(s);
    endfunction

    function automatic logic [RIW-1:0] ovr_res(input ovr_e t);
        return RIW'(RES_CTRL) + RIW'(t);
    endfunction

endpackage

// File: rtl/cycle_detect.sv
module cycle_detect (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic cmd_n,
    output logic start,
    output logic is_cmd,
    output logic is_wr
);
    logic ce_q;

    always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b1;
        else     ce_q <= ce_n;
    end

    always_comb begin
        start  = ce_q & ~ce_n;
        is_cmd = ~cmd_n;
        is_wr  = ~we_n;
    end
endmodule

// File: rtl/select_state.sv
module select_state
    import cycle_router_pkg::*;
#(
    parameter int OP_W = OPW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            is_cmd,
    input  logic            is_wr,
    input  logic [OP_W-1:0] opcode,
    output dsel_e           psrc,
    output dsel_e           pdst,
    output logic            ovr_pend,
    output ovr_e            ovr_tgt
);
    opdec_t dec;

    always_comb dec = decode_op(OPW'(opcode));

    always_ff @(posedge clk) begin
        if (rst) begin
            psrc     <= DSEL_CMP;
            pdst     <= DSEL_CMP;
            ovr_pend <= 1'b0;
            ovr_tgt  <= OVR_CTRL;
        end else if (start) begin
            if (!is_cmd || ovr_pend) begin
                ovr_pend <= 1'b0;
            end else if (is_wr) begin
                case (dec.kind)
                    OP_SRC:  psrc <= dsel_e'(dec.arg[1:0]);
                    OP_DST:  pdst <= dsel_e'(dec.arg[1:0]);
                    OP_OVR: begin
                        ovr_pend <= 1'b1;
                        ovr_tgt  <= ovr_e'(dec.arg);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/route_out.sv
module route_out
    import cycle_router_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int N_RES  = NRES
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ce_n,
    input  logic                         start,
    input  logic                         is_cmd,
    input  logic                         is_wr,
    input  logic [DATA_W-1:0]            wdata,
    input  dsel_e                        psrc,
    input  dsel_e                        pdst,
    input  logic                         ovr_pend,
    input  ovr_e                         ovr_tgt,
    input  logic [N_RES-1:0][DATA_W-1:0] res_rdata,
    output logic [N_RES-1:0]             wr_stb,
    output logic [N_RES-1:0]             rd_stb,
    output logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_oe
);
    localparam int IW = $clog2(N_RES);

    logic [IW-1:0]     res_idx, sel_q;
    logic              hit, rb, rb_q, rd_act;
    logic [DATA_W-1:0] rb_val, rb_q_val;

    always_comb begin
        res_idx = '0;
        hit     = 1'b1;
        rb      = 1'b0;
        rb_val  = '0;
        if (!is_cmd) begin
            res_idx = IW'(is_wr ? dsel_res(pdst) : dsel_res(psrc));
        end else if (ovr_pend) begin
            if (ovr_tgt == OVR_PSRC || ovr_tgt == OVR_PDST) begin
                hit    = 1'b0;
                rb     = ~is_wr;
                rb_val = DATA_W'(ovr_tgt == OVR_PSRC ? psrc : pdst);
            end else begin
                res_idx = IW'(ovr_res(ovr_tgt));
            end
        end else begin
            res_idx = IW'(is_wr ? RES_INSTR : RES_STAT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb   <= '0;
            rd_stb   <= '0;
            wr_data  <= '0;
            sel_q    <= '0;
            rb_q     <= 1'b0;
            rb_q_val <= '0;
            rd_act   <= 1'b0;
        end else begin
            wr_stb <= '0;
            rd_stb <= '0;
            if (ce_n) rd_act <= 1'b0;
            if (start) begin
                if (hit && is_wr)  wr_stb <= N_RES'(1) << res_idx;
                if (hit && !is_wr) rd_stb <= N_RES'(1) << res_idx;
                wr_data  <= wdata;
                sel_q    <= res_idx;
                rb_q     <= rb;
                rb_q_val <= rb_val;
                rd_act   <= ~is_wr;
            end
        end
    end

    always_comb begin
        rd_oe   = rd_act & ~ce_n;
        rd_data = '0;
        if (rd_oe) rd_data = rb_q ? rb_q_val : res_rdata[sel_q];
    end
endmodule

// File: rtl/cycle_router.sv
module cycle_router
    import cycle_router_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int N_RES  = NRES
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ce_n,
    input  logic                         we_n,
    input  logic                         cmd_n,
    input  logic [DATA_W-1:0]            bus_in,
    input  logic [N_RES-1:0][DATA_W-1:0] res_rdata,
    output logic [N_RES-1:0]             wr_stb,
    output logic [N_RES-1:0]             rd_stb,
    output logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_oe
);
    logic  start, is_cmd, is_wr, ovr_pend;
    dsel_e psrc, pdst;
    ovr_e  ovr_tgt;

    cycle_detect u_det (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cmd_n(cmd_n),
        .start(start), .is_cmd(is_cmd), .is_wr(is_wr)
    );

    select_state #(.OP_W(OPW)) u_sel (
        .clk(clk), .rst(rst), .start(start), .is_cmd(is_cmd), .is_wr(is_wr),
        .opcode(bus_in[OPW-1:0]), .psrc(psrc), .pdst(pdst),
        .ovr_pend(ovr_pend), .ovr_tgt(ovr_tgt)
    );

    route_out #(.DATA_W(DATA_W), .N_RES(N_RES)) u_out (
        .clk(clk), .rst(rst), .ce_n(ce_n), .start(start), .is_cmd(is_cmd),
        .is_wr(is_wr), .wdata(bus_in), .psrc(psrc), .pdst(pdst),
        .ovr_pend(ovr_pend), .ovr_tgt(ovr_tgt), .res_rdata(res_rdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );
endmodule

// File: rtl/cycle_router_chk.sv
module cycle_router_chk #(
    parameter int DATA_W = 16,
    parameter int N_RES  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              cmd_n,
    input logic [N_RES-1:0]  wr_stb,
    input logic [N_RES-1:0]  rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_oe
);
    assert_wr_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));
    assert_rd_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_stb));
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        (|wr_stb || |rd_stb) |=> !(|wr_stb || |rd_stb));
    assert_stb_after_ce_R1: assert property (@(posedge clk) disable iff (rst)
        (|wr_stb || |rd_stb) |-> $past(!ce_n));
    assert_no_instr_read_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_stb[4] && !wr_stb[5]);
    assert_data_write_data_res_R4: assert property (@(posedge clk) disable iff (rst)
        (|wr_stb && $past(cmd_n)) |-> (wr_stb[N_RES-1:4] == '0));
    assert_oe_ce_low_R9: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> !ce_n);
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_oe |-> (rd_data == '0));
endmodule

bind cycle_router cycle_router_chk #(.DATA_W(DATA_W), .N_RES(N_RES)) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cmd_n(cmd_n), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .rd_data(rd_data), .rd_oe(rd_oe)
);

// File: tb/sim_cycle_router.sv
`timescale 1ns/1ps
module sim_cycle_router;
    localparam int NV = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, cmd_n = 1'b1;
    logic [15:0] bus_in = '0;
    logic [9:0][15:0] res_rdata;
    logic [9:0] wr_stb, rd_stb;
    logic [15:0] wr_data, rd_data;
    logic rd_oe;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    always_comb
        for (int i = 0; i < 10; i++) res_rdata[i] = {4'hA, 4'(i), 4'hA, 4'(i)};

    cycle_router u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cmd_n(cmd_n),
        .bus_in(bus_in), .res_rdata(res_rdata), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        cmd;
        logic        wr;
        logic [15:0] d;
        logic [9:0]  ew;
        logic [9:0]  er;
        logic        eoe;
        logic [15:0] erd;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{4'd2, 1'b0,1'b1,16'h1234,10'h001,10'h000,1'b0,16'h0000}, // R2 default dest
        '{4'd2, 1'b0,1'b0,16'h0000,10'h000,10'h001,1'b1,16'hA0A0}, // R2 default source
        '{4'd3, 1'b1,1'b0,16'h0000,10'h000,10'h020,1'b1,16'hA5A5}, // R3 status
        '{4'd4, 1'b1,1'b1,16'h0012,10'h010,10'h000,1'b0,16'h0000}, // R4 src=mask2
        '{4'd4, 1'b0,1'b0,16'h0000,10'h000,10'h004,1'b1,16'hA2A2}, // R4
        '{4'd4, 1'b0,1'b1,16'h5A5A,10'h001,10'h000,1'b0,16'h0000}, // R4 dest unchanged
        '{4'd4, 1'b1,1'b1,16'h0017,10'h010,10'h000,1'b0,16'h0000}, // R4 dst=mem
        '{4'd10,1'b0,1'b1,16'hC3C3,10'h008,10'h000,1'b0,16'h0000}, // R10
        '{4'd5, 1'b1,1'b1,16'h0020,10'h010,10'h000,1'b0,16'h0000}, // R5 ovr ctrl
        '{4'd5, 1'b1,1'b1,16'hBEEF,10'h040,10'h000,1'b0,16'h0000}, // R5
        '{4'd8, 1'b1,1'b1,16'h0099,10'h010,10'h000,1'b0,16'h0000}, // R8 unknown op
        '{4'd8, 1'b0,1'b0,16'h0000,10'h000,10'h004,1'b1,16'hA2A2}, // R8 no change
        '{4'd6, 1'b1,1'b1,16'h0024,10'h010,10'h000,1'b0,16'h0000}, // R6
        '{4'd6, 1'b1,1'b0,16'h0000,10'h000,10'h000,1'b1,16'h0002}, // R6 src code
        '{4'd6, 1'b1,1'b1,16'h0025,10'h010,10'h000,1'b0,16'h0000}, // R6
        '{4'd6, 1'b1,1'b0,16'h0000,10'h000,10'h000,1'b1,16'h0003}, // R6 dst code
        '{4'd7, 1'b1,1'b1,16'h0023,10'h010,10'h000,1'b0,16'h0000}, // R7
        '{4'd7, 1'b0,1'b0,16'h0000,10'h000,10'h004,1'b1,16'hA2A2}, // R7 data cycle
        '{4'd7, 1'b1,1'b0,16'h0000,10'h000,10'h020,1'b1,16'hA5A5}, // R7 cancelled
        '{4'd5, 1'b1,1'b1,16'h0022,10'h010,10'h000,1'b0,16'h0000}, // R5 addr
        '{4'd5, 1'b1,1'b0,16'h0000,10'h000,10'h100,1'b1,16'hA8A8}, // R5 read
        '{4'd5, 1'b1,1'b1,16'h0021,10'h010,10'h000,1'b0,16'h0000}, // R5 seg
        '{4'd5, 1'b1,1'b1,16'h0055,10'h080,10'h000,1'b0,16'h0000}, // R5
        '{4'd8, 1'b1,1'b1,16'h0113,10'h010,10'h000,1'b0,16'h0000}, // R8 high bits
        '{4'd8, 1'b0,1'b0,16'h0000,10'h000,10'h008,1'b1,16'hA3A3}, // R8 src=mem
        '{4'd6, 1'b1,1'b1,16'h0024,10'h010,10'h000,1'b0,16'h0000}, // R6
        '{4'd6, 1'b1,1'b1,16'h7777,10'h000,10'h000,1'b0,16'h0000}, // R6 no strobe
        '{4'd5, 1'b1,1'b0,16'h0000,10'h000,10'h020,1'b1,16'hA5A5}, // R5 lapsed
        '{4'd5, 1'b1,1'b1,16'h0023,10'h010,10'h000,1'b0,16'h0000}, // R5 nfree
        '{4'd5, 1'b1,1'b0,16'h0000,10'h000,10'h200,1'b1,16'hA9A9}  // R5
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic c, input logic w, input logic [15:0] d);
        @(negedge clk);
        ce_n = 1'b0; cmd_n = ~c; we_n = ~w; bus_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_end;
        ce_n = 1'b1; we_n = 1'b1; cmd_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        check("R2 wr_stb", 32'(wr_stb), 0);
        check("R2 rd_stb", 32'(rd_stb), 0);
        check("R2 rd_oe", 32'(rd_oe), 0);

        for (int i = 0; i < NV; i++) begin
            bus_cycle(VEC[i].cmd, VEC[i].wr, VEC[i].d);
            check($sformatf("R%0d/R1 row%0d wr_stb", VEC[i].req, i), 32'(wr_stb), 32'(VEC[i].ew));
            check($sformatf("R%0d/R1 row%0d rd_stb", VEC[i].req, i), 32'(rd_stb), 32'(VEC[i].er));
            check($sformatf("R%0d/R9 row%0d rd_oe", VEC[i].req, i), 32'(rd_oe), 32'(VEC[i].eoe));
            check($sformatf("R%0d row%0d rd_data", VEC[i].req, i), 32'(rd_data), 32'(VEC[i].erd));
            if (VEC[i].ew != '0)
                check($sformatf("R10 row%0d wr_data", i), 32'(wr_data), 32'(VEC[i].d));
            bus_end();
            // R9: enable drops once chip enable rises
            check($sformatf("R9 row%0d oe after ce", i), 32'(rd_oe), 0);
            check($sformatf("R9 row%0d data after ce", i), 32'(rd_data), 0);
        end

        // R1: chip enable held low gives one strobe only
        cnt = 0;
        bus_cycle(1'b0, 1'b1, 16'h0F0F);
        for (int k = 0; k < 5; k++) begin
            if (wr_stb != '0) cnt++;
            @(negedge clk);
        end
        check("R1 single strobe", 32'(cnt), 1);
        // R9: read data held while ce low
        bus_end();
        bus_cycle(1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        check("R9 held oe", 32'(rd_oe), 1);
        check("R9 held data", 32'(rd_data), 32'h0000A3A3);
        bus_end();

        // R2: reset restores comparand selection
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_cycle(1'b0, 1'b0, 16'h0000);
        check("R2 rst src", 32'(rd_stb), 32'h001);
        bus_end();
        bus_cycle(1'b0, 1'b1, 16'h4321);
        check("R2 rst dst", 32'(wr_stb), 32'h001);
        bus_end();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule